// File: doc/BRIEF.md
# USB Low-Speed Token Filter

This block sits after the packet decoder of a low-speed USB device and before its two endpoint buffers. Every decoded token arrives as one record carrying the packet identifier, the seven-bit target address, the endpoint number and a flag that says whether the token's CRC was good. The filter compares the address and endpoint against the device's own address register. For tokens that match, it decides the handshake: accept the data stage, answer NAK, or send data. It also raises a one-cycle completion strobe per endpoint when a transaction has really finished.

Endpoint 0 carries control traffic and takes SETUP, OUT and IN. Endpoint 1 only sends data to the host. An OUT that is answered with NAK leaves no completion behind. Each byte written into an endpoint FIFO holds the processor off for three clock cycles, and the block drives that hold-off as a level output.

Top module: `usbls_token_gate`

## Requirements
- R1: The address register resets to 0. A write through `addr_we` stores `addr_wdata[6:0]` and ignores bit 7. `addr_rdata` always reads `{1'b0, address}`, and a write shows on `addr_rdata` in the cycle after the write edge.
- R2: A token with `tok_crc_ok` low, with an address other than the register, or with an endpoint number of 2 or more gives no response (`resp_valid` stays low).
- R3: A SETUP token (PID 4'b1101) to endpoint 0 is answered with ACCEPT (`resp_kind` 2'b01) one cycle after the token, whatever the state of `ep0_ready`.
- R4: An OUT token (PID 4'b0001) to endpoint 0 is answered with ACCEPT when `ep0_ready` is high and with NAK (`resp_kind` 2'b10) when it is low, one cycle after the token.
- R5: An OUT or SETUP token to endpoint 1 gives no response.
- R6: An IN token (PID 4'b1001) to endpoint N is answered with NAK when that endpoint's ready input is low and with DATA (`resp_kind` 2'b11) when it is high, one cycle after the token.
- R7: After a DATA response on endpoint N, an `hs_valid` pulse with `hs_ack` high raises that endpoint's done strobe for exactly one cycle, in the cycle after the pulse. With `hs_ack` low there is no strobe, and the transaction is closed either way.
- R8: After an accepted SETUP or OUT, an `rx_done` pulse raises `ep0_done` for one cycle, in the cycle after the pulse. After a NAKed OUT, `rx_done` raises no strobe.
- R9: Each cycle with `fifo_wr` high adds three cycles of `cpu_stall`, starting in the cycle after the write. Writes on back-to-back cycles add up, so N writes give 3N stall cycles.
- R10: A change of address applies to the next token. After the change, tokens to the old address are ignored and tokens to the new address are answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tok_valid | input | 1 | Token record valid for one cycle |
| tok_pid | input | 4 | Packet identifier: OUT 0001, IN 1001, SETUP 1101 |
| tok_addr | input | 7 | Token target address |
| tok_ep | input | 4 | Token endpoint number |
| tok_crc_ok | input | 1 | Token CRC was good |
| ep0_ready | input | 1 | Endpoint 0 is armed (can take OUT data / has IN data) |
| ep1_ready | input | 1 | Endpoint 1 has IN data armed |
| rx_done | input | 1 | Data stage of a SETUP/OUT was received |
| hs_valid | input | 1 | Host handshake phase after sent data ended |
| hs_ack | input | 1 | With hs_valid: host answered ACK |
| fifo_wr | input | 1 | One byte written into an endpoint FIFO this cycle |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | 8 | Address register write data (bit 7 ignored) |
| addr_rdata | output | 8 | Address register read value, bit 7 zero |
| resp_valid | output | 1 | Handshake decision valid |
| resp_kind | output | 2 | 01 ACCEPT, 10 NAK, 11 DATA |
| ep0_done | output | 1 | Endpoint 0 completion strobe |
| ep1_done | output | 1 | Endpoint 1 completion strobe |
| cpu_stall | output | 1 | Processor hold-off during FIFO writes |

## Verification
A handshake decision is due in the cycle after the token edge. A done strobe is due in the cycle after the `rx_done` or `hs_valid` edge. `addr_rdata` follows one edge after a write, and `cpu_stall` rises one edge after a FIFO write and stays high for three cycles per byte. The bench drives inputs on the falling edge and steps its reference model on the rising edge with the same registered latency. It then compares every output at the next falling edge, so each result is checked in exactly the cycle it is due and also in every cycle where it must be absent.

// File: rtl/usbls_tg_pkg.sv
package usbls_tg_pkg;

  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_SETUP = 4'b1101;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'b00,
    RSP_ACCEPT = 2'b01,
    RSP_NAK    = 2'b10,
    RSP_DATA   = 2'b11
  } rsp_e;

  // Handshake rule set for a token that already matched address and endpoint.
  function automatic rsp_e tg_decide(input logic [3:0] pid, input logic ep_is1,
                                     input logic ready);
    rsp_e r;
    r = RSP_NONE;
    if (ep_is1) begin
      if (pid == PID_IN) r = ready ? RSP_DATA : RSP_NAK;
    end else begin
      if (pid == PID_SETUP)    r = RSP_ACCEPT;
      else if (pid == PID_OUT) r = ready ? RSP_ACCEPT : RSP_NAK;
      else if (pid == PID_IN)  r = ready ? RSP_DATA : RSP_NAK;
    end
    return r;
  endfunction

endpackage

// File: rtl/usbls_tg_match.sv
module usbls_tg_match
  import usbls_tg_pkg::*;
#(
  parameter int AW  = 7,
  parameter int EPW = 4,
  parameter int NEP = 2
) (
  input  logic           tok_valid,
  input  logic [3:0]     tok_pid,
  input  logic [AW-1:0]  tok_addr,
  input  logic [EPW-1:0] tok_ep,
  input  logic           tok_crc_ok,
  input  logic [AW-1:0]  dev_addr,
  input  logic [NEP-1:0] ep_ready,
  output logic           hit,
  output logic           ep_sel,
  output rsp_e           decision
);
  localparam logic [EPW-1:0] EP_LAST = EPW'(NEP - 1);

  logic ep_ok;
  logic sel_ready;

  assign ep_ok     = (tok_ep <= EP_LAST);
  assign hit       = tok_valid && tok_crc_ok && (tok_addr == dev_addr) && ep_ok;
  assign ep_sel    = tok_ep[0];
  assign sel_ready = ep_ready[ep_sel];
  assign decision  = hit ? tg_decide(tok_pid, ep_sel, sel_ready) : RSP_NONE;
endmodule

// File: rtl/usbls_tg_events.sv
module usbls_tg_events
  import usbls_tg_pkg::*;
#(
  parameter int NEP = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic           ep_sel,
  input  rsp_e           decision,
  input  logic           rx_done,
  input  logic           hs_valid,
  input  logic           hs_ack,
  output logic [NEP-1:0] done
);
  logic           rx_pend;
  logic [NEP-1:0] tx_pend;
  logic [NEP-1:0] done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pend <= 1'b0;
      tx_pend <= '0;
      done_q  <= '0;
    end else begin
      done_q <= '0;
      if (rx_done && rx_pend) begin
        done_q[0] <= 1'b1;
        rx_pend   <= 1'b0;
      end
      if (hs_valid) begin
        for (int i = 0; i < NEP; i++) begin
          if (tx_pend[i] && hs_ack) done_q[i] <= 1'b1;
        end
        tx_pend <= '0;
      end
      if (hit && decision != RSP_NONE) begin
        if (decision == RSP_DATA)
          tx_pend[ep_sel] <= 1'b1;
        else if (!ep_sel && decision == RSP_ACCEPT)
          rx_pend <= 1'b1;
        else if (!ep_sel && decision == RSP_NAK)
          rx_pend <= 1'b0;
      end
    end
  end

  assign done = done_q;
endmodule

// File: rtl/usbls_tg_stall.sv
module usbls_tg_stall #(
  parameter int PER_BYTE  = 3,
  parameter int MAX_BYTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_wr,
  output logic stall
);
  localparam int MAXC = PER_BYTE * MAX_BYTES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] stall_next(input logic [CW-1:0] c, input logic w);
    int s;
    s = int'(c);
    if (s != 0) s = s - 1;
    if (w) s = s + PER_BYTE;
    if (s > MAXC) s = MAXC;
    return CW'(s);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= stall_next(cnt, fifo_wr);
  end

  assign stall = (cnt != '0);
endmodule

// File: rtl/usbls_token_gate.sv
module usbls_token_gate
  import usbls_tg_pkg::*;
#(
  parameter int AW        = 7,
  parameter int EPW       = 4,
  parameter int STALL_PB  = 3,
  parameter int MAX_BYTES = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tok_valid,
  input  logic [3:0]     tok_pid,
  input  logic [AW-1:0]  tok_addr,
  input  logic [EPW-1:0] tok_ep,
  input  logic           tok_crc_ok,
  input  logic           ep0_ready,
  input  logic           ep1_ready,
  input  logic           rx_done,
  input  logic           hs_valid,
  input  logic           hs_ack,
  input  logic           fifo_wr,
  input  logic           addr_we,
  input  logic [AW:0]    addr_wdata,
  output logic [AW:0]    addr_rdata,
  output logic           resp_valid,
  output logic [1:0]     resp_kind,
  output logic           ep0_done,
  output logic           ep1_done,
  output logic           cpu_stall
);
  localparam int NEP = 2;

  logic [AW-1:0]  dev_addr;
  logic           tok_hit;
  logic           tok_ep_sel;
  rsp_e           tok_dec;
  logic [NEP-1:0] ep_done;
  logic           resp_valid_q;
  rsp_e           resp_kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dev_addr <= '0;
    else if (addr_we) dev_addr <= addr_wdata[AW-1:0];
  end

  usbls_tg_match #(.AW(AW), .EPW(EPW), .NEP(NEP)) u_match (
    .tok_valid (tok_valid),
    .tok_pid   (tok_pid),
    .tok_addr  (tok_addr),
    .tok_ep    (tok_ep),
    .tok_crc_ok(tok_crc_ok),
    .dev_addr  (dev_addr),
    .ep_ready  ({ep1_ready, ep0_ready}),
    .hit       (tok_hit),
    .ep_sel    (tok_ep_sel),
    .decision  (tok_dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_kind_q  <= RSP_NONE;
    end else begin
      resp_valid_q <= (tok_dec != RSP_NONE);
      resp_kind_q  <= tok_dec;
    end
  end

  usbls_tg_events #(.NEP(NEP)) u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (tok_hit),
    .ep_sel  (tok_ep_sel),
    .decision(tok_dec),
    .rx_done (rx_done),
    .hs_valid(hs_valid),
    .hs_ack  (hs_ack),
    .done    (ep_done)
  );

  usbls_tg_stall #(.PER_BYTE(STALL_PB), .MAX_BYTES(MAX_BYTES)) u_stall (
    .clk    (clk),
    .rst_n  (rst_n),
    .fifo_wr(fifo_wr),
    .stall  (cpu_stall)
  );

  assign addr_rdata = {1'b0, dev_addr};
  assign resp_valid = resp_valid_q;
  assign resp_kind  = resp_kind_q;
  assign ep0_done   = ep_done[0];
  assign ep1_done   = ep_done[1];
endmodule

// File: rtl/usbls_tg_chk.sv
module usbls_tg_chk
  import usbls_tg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tok_valid,
  input logic [3:0] tok_pid,
  input logic [3:0] tok_ep,
  input logic       tok_hit,
  input logic       ep0_ready,
  input logic       rx_done,
  input logic       hs_valid,
  input logic       hs_ack,
  input logic       fifo_wr,
  input logic [7:0] addr_rdata,
  input logic       resp_valid,
  input logic [1:0] resp_kind,
  input logic       ep0_done,
  input logic       ep1_done,
  input logic       cpu_stall
);
  a_r1_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr_rdata[7] == 1'b0);

  a_r2_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_hit) |=> !resp_valid);

  a_r3_setup_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_hit && tok_pid == PID_SETUP && tok_ep == 4'd0) |=> (resp_valid && resp_kind == 2'b01));

  a_r4_out_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_hit && tok_pid == PID_OUT && tok_ep == 4'd0 && !ep0_ready) |=> (resp_valid && resp_kind == 2'b10));

  a_r5_ep1_rx_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_hit && tok_ep == 4'd1 && tok_pid != PID_IN) |=> !resp_valid);

  a_r7_ep1_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ep1_done |-> $past(hs_valid && hs_ack));

  a_r8_ep0_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ep0_done |-> $past(rx_done || (hs_valid && hs_ack)));

  a_r9_stall_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> cpu_stall);
endmodule

bind usbls_token_gate usbls_tg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tok_valid (tok_valid),
  .tok_pid   (tok_pid),
  .tok_ep    (tok_ep),
  .tok_hit   (tok_hit),
  .ep0_ready (ep0_ready),
  .rx_done   (rx_done),
  .hs_valid  (hs_valid),
  .hs_ack    (hs_ack),
  .fifo_wr   (fifo_wr),
  .addr_rdata(addr_rdata),
  .resp_valid(resp_valid),
  .resp_kind (resp_kind),
  .ep0_done  (ep0_done),
  .ep1_done  (ep1_done),
  .cpu_stall (cpu_stall)
);

// File: tb/sim_usbls_token_gate.sv
`timescale 1ns/100ps
module sim_usbls_token_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_valid = 1'b0;
  logic [3:0] tok_pid = 4'd0;
  logic [6:0] tok_addr = 7'd0;
  logic [3:0] tok_ep = 4'd0;
  logic       tok_crc_ok = 1'b0;
  logic       ep0_ready = 1'b0;
  logic       ep1_ready = 1'b0;
  logic       rx_done = 1'b0;
  logic       hs_valid = 1'b0;
  logic       hs_ack = 1'b0;
  logic       fifo_wr = 1'b0;
  logic       addr_we = 1'b0;
  logic [7:0] addr_wdata = 8'd0;
  logic [7:0] addr_rdata;
  logic       resp_valid;
  logic [1:0] resp_kind;
  logic       ep0_done;
  logic       ep1_done;
  logic       cpu_stall;

  always #2.5 clk = ~clk;

  usbls_token_gate u0 (.*);

  int    vectors = 0;
  int    miscompares = 0;
  bit    done_run = 0;
  string cur_req = "R1";

  // Behavioural reference model, stepped on the rising edge
  int m_addr = 0, m_kind = 0, m_stall = 0;
  bit m_rv = 0, m_d0 = 0, m_d1 = 0, m_rxp = 0;
  bit m_txp[2] = '{0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_kind = 0; m_stall = 0; m_rv = 0; m_d0 = 0; m_d1 = 0;
      m_rxp = 0; m_txp[0] = 0; m_txp[1] = 0;
    end else begin
      int kind;
      int e;
      bit rdy;
      kind = 0;
      e = int'(tok_ep);
      m_d0 = 0; m_d1 = 0;
      if (rx_done && m_rxp) begin m_d0 = 1; m_rxp = 0; end
      if (hs_valid) begin
        if (hs_ack && m_txp[0]) m_d0 = 1;
        if (hs_ack && m_txp[1]) m_d1 = 1;
        m_txp[0] = 0; m_txp[1] = 0;
      end
      if (tok_valid && tok_crc_ok && int'(tok_addr) == m_addr && e < 2) begin
        rdy = (e == 0) ? ep0_ready : ep1_ready;
        if (tok_pid == 4'b1001) kind = rdy ? 3 : 2;
        else if (e == 0 && tok_pid == 4'b1101) kind = 1;
        else if (e == 0 && tok_pid == 4'b0001) kind = rdy ? 1 : 2;
        if (kind == 3) m_txp[e] = 1;
        if (e == 0 && kind == 1) m_rxp = 1;
        if (e == 0 && kind == 2 && tok_pid == 4'b0001) m_rxp = 0;
      end
      m_rv = (kind != 0);
      m_kind = kind;
      if (m_stall > 0) m_stall--;
      if (fifo_wr) m_stall += 3;
      if (addr_we) m_addr = int'(addr_wdata[6:0]);
    end
  end

  always @(negedge clk) begin
    if (!done_run) begin
      bit bad;
      bad = 0;
      vectors++;
      if (addr_rdata != 8'(m_addr)) begin
        bad = 1;
        $display("FAIL %s addr_rdata act=%0h exp=%0h", cur_req, addr_rdata, m_addr);
      end
      if (resp_valid != m_rv || (m_rv && resp_kind != 2'(m_kind))) begin
        bad = 1;
        $display("FAIL %s resp act=%0b/%0d exp=%0b/%0d", cur_req, resp_valid, resp_kind, m_rv, m_kind);
      end
      if (ep0_done != m_d0 || ep1_done != m_d1) begin
        bad = 1;
        $display("FAIL %s done act=%0b%0b exp=%0b%0b", cur_req, ep1_done, ep0_done, m_d1, m_d0);
      end
      if (cpu_stall != (m_stall != 0)) begin
        bad = 1;
        $display("FAIL %s cpu_stall act=%0b exp=%0b", cur_req, cpu_stall, m_stall != 0);
      end
      if (bad) miscompares++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_tok(input logic [3:0] pid, input logic [6:0] a, input logic [3:0] e,
                          input logic crc);
    @(negedge clk);
    tok_valid = 1; tok_pid = pid; tok_addr = a; tok_ep = e; tok_crc_ok = crc;
    @(negedge clk);
    tok_valid = 0;
    idle(2);
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_done = 1;
    @(negedge clk); rx_done = 0;
    idle(2);
  endtask

  task automatic pulse_hs(input logic ack);
    @(negedge clk); hs_valid = 1; hs_ack = ack;
    @(negedge clk); hs_valid = 0; hs_ack = 0;
    idle(2);
  endtask

  task automatic write_addr(input logic [7:0] v);
    @(negedge clk); addr_we = 1; addr_wdata = v;
    @(negedge clk); addr_we = 0;
    idle(1);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    cur_req = "R1"; idle(2);                 // R1 reset value 0
    write_addr(8'h85);                       // R1 bit 7 dropped -> 0x05
    cur_req = "R10";
    send_tok(4'b1101, 7'd0, 4'd0, 1'b1);     // R10 old address ignored
    send_tok(4'b1101, 7'd5, 4'd0, 1'b1);     // R10 new address answered
    cur_req = "R2";
    send_tok(4'b1101, 7'd5, 4'd0, 1'b0);     // R2 CRC bad
    send_tok(4'b1001, 7'd5, 4'd2, 1'b1);     // R2 endpoint 2
    send_tok(4'b1001, 7'd5, 4'd15, 1'b1);    // R2 endpoint 15
    send_tok(4'b0001, 7'd6, 4'd0, 1'b1);     // R2 wrong address
    cur_req = "R3"; ep0_ready = 0;
    send_tok(4'b1101, 7'd5, 4'd0, 1'b1);     // R3 SETUP while not ready
    cur_req = "R8"; pulse_rx();              // R8 completion after accepted SETUP
    cur_req = "R4";
    send_tok(4'b0001, 7'd5, 4'd0, 1'b1);     // R4 NAK
    cur_req = "R8"; pulse_rx();              // R8 no event after NAK
    cur_req = "R4"; ep0_ready = 1;
    send_tok(4'b0001, 7'd5, 4'd0, 1'b1);     // R4 ACCEPT
    cur_req = "R8"; pulse_rx();
    cur_req = "R5";
    send_tok(4'b0001, 7'd5, 4'd1, 1'b1);     // R5 OUT to ep1
    send_tok(4'b1101, 7'd5, 4'd1, 1'b1);     // R5 SETUP to ep1
    cur_req = "R6"; ep1_ready = 0;
    send_tok(4'b1001, 7'd5, 4'd1, 1'b1);     // R6 NAK
    ep1_ready = 1;
    send_tok(4'b1001, 7'd5, 4'd1, 1'b1);     // R6 DATA
    cur_req = "R7"; pulse_hs(1'b1);          // R7 ep1_done
    cur_req = "R6"; ep0_ready = 1;
    send_tok(4'b1001, 7'd5, 4'd0, 1'b1);     // R6 DATA on ep0
    cur_req = "R7"; pulse_hs(1'b0);          // R7 no ACK, no strobe
    pulse_hs(1'b1);                          // R7 closed, still no strobe
    ep0_ready = 0;
    cur_req = "R6";
    send_tok(4'b1001, 7'd5, 4'd0, 1'b1);     // R6 NAK on ep0
    cur_req = "R9";
    @(negedge clk); fifo_wr = 1;
    @(negedge clk); fifo_wr = 0;
    idle(5);
    @(negedge clk); fifo_wr = 1;
    idle(3);
    @(negedge clk); fifo_wr = 0;             // R9 four bytes -> 12 cycles
    idle(16);
    cur_req = "R1"; write_addr(8'h7F);       // R1 full 7-bit value
    idle(2);
    done_run = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      done_run = 1;
      miscompares++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule